// File: doc/BRIEF.md
# Solar Charger Supervisory Sequencer

This block is the slow supervisory layer of a solar battery charger. It advances only on a 1 ms tick enable and decides how the fast current regulator is used: in closed-loop mode it supplies a current reference, and in open-loop mode it supplies a duty value directly. It also drives the battery contactor. The sequence runs from an idle start through pre-charge of the converter output capacitor, contactor closing, and regulated charging. If the regulator stays saturated, a fallback maximum-power search runs in open loop. The remaining states are a standby point and a timed contactor opening.

During pre-charge the capacitor voltage is not measured. It is estimated as the regulator duty multiplied by the solar voltage. When the panel cannot deliver the requested current, the scan lowers the duty one step per tick from full scale and keeps the duty at which the inductor current peaked. It then raises the duty back to that value in the same steps and holds it. Closed-loop charging is retried after a period. Every threshold, delay and step size is a parameter. All delays are counted in ticks by one shared down-counter that is reloaded on each state change.

Top module: `solar_sup_fsm`

## Requirements
- R1: While reset is low, and on release, the block is in the start state: loop open, current reference 0, open-loop duty 0, contactor open.
- R2: From start, the block enters pre-charge on a tick only when the requested current is above 0 and the solar voltage is strictly greater than the battery voltage plus START_MARGIN.
- R3: In pre-charge the loop is closed, the reference equals I_PRE and the contactor stays open.
- R4: Pre-charge ends only once SETTLE_MS ticks have passed since entry and the estimate (regulator duty × solar voltage) >> D_W is strictly above the battery voltage. The block then closes the contactor with the loop open and duty 0, and enters charging on the tick after CLOSE_MS further ticks.
- R5: In charging the loop is closed, the contactor is closed and the reference follows the requested current. The scan starts only after the saturation flag has been high on SAT_MS+1 consecutive ticks; any tick without saturation restarts that count.
- R6: On scan entry the loop opens at duty DUTY_MAX. The inductor current and DUTY_MAX are stored as the best point.
- R7: On each scan tick, a current above the stored best is recorded together with the present duty. The duty then drops by DUTY_STEP. The scan ends, with no further drop, on the tick where the duty is already at or below DUTY_STEP.
- R8: After the scan, the duty rises by DUTY_STEP per tick until it equals the best duty. That point is then held, and charging is retried on the tick after RETRY_MS held ticks.
- R9: During the scan, the ramp-up or the hold, an inductor current strictly above the requested current returns the block to charging.
- R10: If the best duty is at or below DUTY_STEP, the ramp ends in standby: contactor closed, loop open, duty 0. Charging is retried after RETRY_MS ticks.
- R11: In any contactor-closed state, a request of 0 or less, or a solar voltage below the battery voltage, opens the contactor with duty 0. The block returns to start on the tick after OPEN_MS further ticks. The same condition in pre-charge returns the block straight to start.
- R12: Without a tick, the state, the duty and the contactor do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 ms step enable |
| i_req_i | input | I_W | Requested charge current, signed |
| u_sol_i | input | V_W | Measured solar voltage |
| u_bat_i | input | V_W | Measured battery voltage |
| i_ind_i | input | I_W | Measured inductor current, signed |
| reg_duty_i | input | D_W | Duty produced by the current regulator |
| reg_sat_i | input | 1 | Regulator held at maximum duty |
| loop_closed_o | output | 1 | 1 = closed-loop current regulation, 0 = open-loop duty |
| i_ref_o | output | I_W | Current reference for the regulator, signed |
| duty_ol_o | output | D_W | Open-loop duty command |
| contactor_o | output | 1 | Battery contactor command |

## Verification
Every output is decoded from registers that update on a clock edge where tick_i is high. A state decision therefore appears one edge after the inputs that cause it. The exception is the charging reference, which follows i_req_i with no delay. A delay parameter of d loads the counter on entry, so the exit decision falls on the (d+1)-th tick after the entry edge. Each stimulus row gives the exact number of edges to wait, and the outputs are sampled 1 ns after the last of those edges, with new inputs applied at the same moment. Off-by-one errors in the counters or in the step arithmetic therefore appear as a wrong state or duty in a specific row.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [3:0] {
    ST_START, ST_PRECHG, ST_CLOSING, ST_CHARGE, ST_SCAN,
    ST_RAMP, ST_HOLD, ST_STANDBY, ST_OPENING
  } sup_state_e;

  typedef enum logic [2:0] {
    OP_KEEP, OP_ZERO, OP_LOAD_MAX, OP_STEP_DN, OP_STEP_UP
  } scan_op_e;
endpackage

// File: rtl/sup_delay.sv
module sup_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (tick_i && load_i)   cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sup_scan.sv
module sup_scan
  import sup_pkg::*;
#(
  parameter int D_W       = 12,
  parameter int I_W       = 16,
  parameter int DUTY_MAX  = 4095,
  parameter int DUTY_STEP = 256
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  scan_op_e              op_i,
  input  logic signed [I_W-1:0] i_ind_i,
  output logic [D_W-1:0]        duty_o,
  output logic [D_W-1:0]        best_d_o
);
  localparam logic [D_W-1:0] MAX_V  = D_W'(DUTY_MAX);
  localparam logic [D_W-1:0] STEP_V = D_W'(DUTY_STEP);

  logic [D_W-1:0]        duty_q, best_d_q;
  logic signed [I_W-1:0] best_i_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q   <= '0;
      best_d_q <= '0;
      best_i_q <= '0;
    end else begin
      unique case (op_i)
        OP_ZERO: duty_q <= '0;
        OP_LOAD_MAX: begin
          duty_q   <= MAX_V;
          best_d_q <= MAX_V;
          best_i_q <= i_ind_i;
        end
        OP_STEP_DN: begin
          // record the current measured at the present duty, then step
          if (i_ind_i > best_i_q) begin
            best_i_q <= i_ind_i;
            best_d_q <= duty_q;
          end
          if (duty_q > STEP_V) duty_q <= duty_q - STEP_V;
        end
        OP_STEP_UP: begin
          if (duty_q > MAX_V - STEP_V) duty_q <= MAX_V;
          else                         duty_q <= duty_q + STEP_V;
        end
        default: ;
      endcase
    end
  end

  assign duty_o   = duty_q;
  assign best_d_o = best_d_q;
endmodule

// File: rtl/solar_sup_fsm.sv
module solar_sup_fsm
  import sup_pkg::*;
#(
  parameter int V_W          = 16,
  parameter int I_W          = 16,
  parameter int D_W          = 12,
  parameter int DUTY_MAX     = 4095,
  parameter int DUTY_STEP    = 256,
  parameter int I_PRE        = 100,
  parameter int START_MARGIN = 200,
  parameter int SETTLE_MS    = 20,
  parameter int CLOSE_MS     = 50,
  parameter int SAT_MS       = 1000,
  parameter int RETRY_MS     = 10000,
  parameter int OPEN_MS      = 50
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic signed [I_W-1:0] i_req_i,
  input  logic [V_W-1:0]        u_sol_i,
  input  logic [V_W-1:0]        u_bat_i,
  input  logic signed [I_W-1:0] i_ind_i,
  input  logic [D_W-1:0]        reg_duty_i,
  input  logic                  reg_sat_i,
  output logic                  loop_closed_o,
  output logic signed [I_W-1:0] i_ref_o,
  output logic [D_W-1:0]        duty_ol_o,
  output logic                  contactor_o
);
  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_DLY = max2(max2(max2(SETTLE_MS, CLOSE_MS), max2(SAT_MS, RETRY_MS)), OPEN_MS);
  localparam int CNT_W   = $clog2(MAX_DLY + 1);
  localparam logic [D_W-1:0] STEP_V = D_W'(DUTY_STEP);

  sup_state_e       state_q, state_d;
  scan_op_e         op;
  logic             load, done;
  logic [CNT_W-1:0] load_val;
  logic [D_W-1:0]   duty, best_d;

  // condition decode
  logic [V_W:0]         sol_x, bat_margin;
  logic [V_W+D_W-1:0]   prod;
  logic [V_W-1:0]       u_est;
  logic                 req_pos, go, stop, over;

  assign req_pos    = !i_req_i[I_W-1] && (i_req_i != '0);
  assign sol_x      = {1'b0, u_sol_i};
  assign bat_margin = {1'b0, u_bat_i} + (V_W+1)'(START_MARGIN);
  assign go         = req_pos && (sol_x > bat_margin);
  assign stop       = !req_pos || (u_sol_i < u_bat_i);
  assign prod       = reg_duty_i * u_sol_i;
  assign u_est      = prod[V_W+D_W-1:D_W];
  assign over       = i_ind_i > i_req_i;

  function automatic logic [CNT_W-1:0] dly_of(sup_state_e s);
    case (s)
      ST_PRECHG:             return CNT_W'(SETTLE_MS);
      ST_CLOSING:            return CNT_W'(CLOSE_MS);
      ST_CHARGE:             return CNT_W'(SAT_MS);
      ST_HOLD, ST_STANDBY:   return CNT_W'(RETRY_MS);
      ST_OPENING:            return CNT_W'(OPEN_MS);
      default:               return '0;
    endcase
  endfunction

  always_comb begin
    state_d = state_q;
    op      = OP_KEEP;
    if (tick_i) begin
      unique case (state_q)
        ST_START:   if (go) state_d = ST_PRECHG;
        ST_PRECHG: begin
          if (stop)                          state_d = ST_START;
          else if (done && u_est > u_bat_i)  state_d = ST_CLOSING;
        end
        ST_CLOSING: if (done) state_d = ST_CHARGE;
        ST_CHARGE: begin
          if (stop)                   state_d = ST_OPENING;
          else if (reg_sat_i && done) state_d = ST_SCAN;
        end
        ST_SCAN: begin
          if (stop)       state_d = ST_OPENING;
          else if (over)  state_d = ST_CHARGE;
          else begin
            op = OP_STEP_DN;
            if (duty <= STEP_V) state_d = ST_RAMP;
          end
        end
        ST_RAMP: begin
          if (stop)                state_d = ST_OPENING;
          else if (over)           state_d = ST_CHARGE;
          else if (duty >= best_d) state_d = (best_d <= STEP_V) ? ST_STANDBY : ST_HOLD;
          else                     op = OP_STEP_UP;
        end
        ST_HOLD: begin
          if (stop)              state_d = ST_OPENING;
          else if (over || done) state_d = ST_CHARGE;
        end
        ST_STANDBY: begin
          if (stop)      state_d = ST_OPENING;
          else if (done) state_d = ST_CHARGE;
        end
        ST_OPENING: if (done) state_d = ST_START;
        default:    state_d = ST_START;
      endcase
      if (state_d != state_q && !(state_d inside {ST_RAMP, ST_HOLD}))
        op = (state_d == ST_SCAN) ? OP_LOAD_MAX : OP_ZERO;
    end
  end

  // shared delay reloads on every state change; charging reloads while unsaturated
  assign load     = (state_d != state_q) || (state_q == ST_CHARGE && !reg_sat_i);
  assign load_val = dly_of(state_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_START;
    else         state_q <= state_d;
  end

  sup_delay #(.CNT_W(CNT_W)) u_delay (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  sup_scan #(
    .D_W(D_W), .I_W(I_W), .DUTY_MAX(DUTY_MAX), .DUTY_STEP(DUTY_STEP)
  ) u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .i_ind_i  (i_ind_i),
    .duty_o   (duty),
    .best_d_o (best_d)
  );

  assign loop_closed_o = (state_q == ST_PRECHG) || (state_q == ST_CHARGE);
  assign i_ref_o       = (state_q == ST_PRECHG) ? I_W'(I_PRE) :
                         (state_q == ST_CHARGE) ? i_req_i : '0;
  assign duty_ol_o     = duty;
  assign contactor_o   = state_q inside {ST_CLOSING, ST_CHARGE, ST_SCAN, ST_RAMP,
                                         ST_HOLD, ST_STANDBY};
endmodule

// File: rtl/sup_chk.sv
module sup_chk #(
  parameter int I_W   = 16,
  parameter int D_W   = 12,
  parameter int I_PRE = 100
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tick_i,
  input logic signed [I_W-1:0] i_req_i,
  input logic                  loop_closed_o,
  input logic signed [I_W-1:0] i_ref_o,
  input logic [D_W-1:0]        duty_ol_o,
  input logic                  contactor_o
);
  // R3
  pre_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_closed_o && !contactor_o) |-> (i_ref_o == I_W'(I_PRE)));

  // R4
  close_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(contactor_o) |-> (!loop_closed_o && duty_ol_o == '0));

  // R5
  charge_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_closed_o && contactor_o) |-> (i_ref_o == i_req_i));

  // R11
  open_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(contactor_o) |-> (!loop_closed_o && duty_ol_o == '0 && i_ref_o == '0));

  // R12
  tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(contactor_o) && $stable(duty_ol_o) && $stable(loop_closed_o)));
endmodule

bind solar_sup_fsm sup_chk #(.I_W(I_W), .D_W(D_W), .I_PRE(I_PRE)) u_sup_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .tick_i        (tick_i),
  .i_req_i       (i_req_i),
  .loop_closed_o (loop_closed_o),
  .i_ref_o       (i_ref_o),
  .duty_ol_o     (duty_ol_o),
  .contactor_o   (contactor_o)
);

// File: tb/solar_sup_fsm_test.sv
module solar_sup_fsm_test;
  localparam int V_W = 16, I_W = 16, D_W = 12;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  tick_i = 1'b1;
  logic signed [I_W-1:0] i_req_i = '0;
  logic [V_W-1:0]        u_sol_i = '0;
  logic [V_W-1:0]        u_bat_i = '0;
  logic signed [I_W-1:0] i_ind_i = '0;
  logic [D_W-1:0]        reg_duty_i = '0;
  logic                  reg_sat_i = 1'b0;
  logic                  loop_closed_o;
  logic signed [I_W-1:0] i_ref_o;
  logic [D_W-1:0]        duty_ol_o;
  logic                  contactor_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  solar_sup_fsm #(
    .V_W(V_W), .I_W(I_W), .D_W(D_W), .DUTY_MAX(4095), .DUTY_STEP(1024),
    .I_PRE(50), .START_MARGIN(100), .SETTLE_MS(4), .CLOSE_MS(5),
    .SAT_MS(6), .RETRY_MS(8), .OPEN_MS(3)
  ) uut (.*);

  typedef struct packed {
    int id; int ireq; int usol; int ubat; int iind; int rduty; int sat; int n;
    int eloop; int econt; int eduty; int eref;
  } vec_t;

  localparam int NV = 32;
  // id ireq usol ubat iind rduty sat n | loop cont duty iref
  localparam vec_t VEC [NV] = '{
    '{2, 200, 1050, 950,   0, 4095, 0,  3, 0, 0,    0,   0}, // R2 margin not exceeded
    '{2, 200, 1051, 950,   0, 4095, 0,  1, 1, 0,    0,  50}, // R2 R3 enter pre-charge
    '{4, 200, 1051, 950,   0, 4095, 0,  4, 1, 0,    0,  50}, // R4 settling not done
    '{4, 200, 1051, 950,   0, 3700, 0,  2, 1, 0,    0,  50}, // R4 estimate 949 too low
    '{4, 200, 1051, 950,   0, 3800, 0,  1, 0, 1,    0,   0}, // R4 estimate 975 -> closing
    '{4, 200, 1051, 950,   0, 3800, 0,  5, 0, 1,    0,   0}, // R4 contactor-on delay
    '{5, 200, 1051, 950,   0, 3800, 0,  1, 1, 1,    0, 200}, // R5 charging
    '{5, 300, 1051, 950,   0, 3800, 0, 10, 1, 1,    0, 300}, // R5 reference follows
    '{5, 300, 1051, 950,   0, 3800, 1,  6, 1, 1,    0, 300}, // R5 saturated, not long enough
    '{5, 300, 1051, 950,   0, 3800, 0,  1, 1, 1,    0, 300}, // R5 break restarts count
    '{5, 300, 1051, 950,   0, 3800, 1,  6, 1, 1,    0, 300}, // R5
    '{6, 300, 1051, 950, 100, 3800, 1,  1, 0, 1, 4095,   0}, // R6 scan entry
    '{7, 300, 1051, 950, 150, 3800, 1,  1, 0, 1, 3071,   0}, // R7
    '{7, 300, 1051, 950, 220, 3800, 1,  1, 0, 1, 2047,   0}, // R7 best now 3071
    '{7, 300, 1051, 950, 180, 3800, 1,  1, 0, 1, 1023,   0}, // R7
    '{7, 300, 1051, 950, 120, 3800, 1,  1, 0, 1, 1023,   0}, // R7 scan ends, no drop
    '{8, 300, 1051, 950, 120, 3800, 1,  1, 0, 1, 2047,   0}, // R8 ramp up
    '{8, 300, 1051, 950, 120, 3800, 1,  1, 0, 1, 3071,   0}, // R8
    '{8, 300, 1051, 950, 120, 3800, 1,  1, 0, 1, 3071,   0}, // R8 hold
    '{8, 300, 1051, 950, 120, 3800, 1,  8, 0, 1, 3071,   0}, // R8 hold period
    '{8, 300, 1051, 950, 120, 3800, 1,  1, 1, 1,    0, 300}, // R8 retry charging
    '{6, 300, 1051, 950, 100, 3800, 1,  7, 0, 1, 4095,   0}, // R6 second scan
    '{9, 300, 1051, 950, 300, 3800, 1,  1, 0, 1, 3071,   0}, // R9 equal is not above
    '{9, 300, 1051, 950, 301, 3800, 1,  1, 1, 1,    0, 300}, // R9 above -> charging
    '{6, 300, 1051, 950,  10, 3800, 1,  7, 0, 1, 4095,   0}, // R6 third scan
    '{7, 300, 1051, 950,  10, 3800, 1,  3, 0, 1, 1023,   0}, // R7
    '{10,300, 1051, 950,  50, 3800, 1,  1, 0, 1, 1023,   0}, // R10 best at 1023
    '{10,300, 1051, 950,  50, 3800, 1,  1, 0, 1,    0,   0}, // R10 standby
    '{11,  0, 1051, 950,  50, 3800, 1,  1, 0, 0,    0,   0}, // R11 opening
    '{11,200, 1051, 950,  50, 3800, 1,  4, 0, 0,    0,   0}, // R11 off delay then start
    '{11,200, 1051, 950,  50, 3800, 1,  1, 1, 0,    0,  50}, // R11 start -> pre-charge
    '{11,200,  900, 950,  50, 3800, 1,  1, 0, 0,    0,   0}  // R11 pre-charge abort
  };

  task automatic check(input int id, input int el, input int ec, input int ed, input int er);
    total++;
    if (int'(loop_closed_o) != el || int'(contactor_o) != ec ||
        int'(duty_ol_o) != ed || int'(i_ref_o) != er) begin
      bad++;
      $display("FAIL R%0d: loop=%0d cont=%0d duty=%0d iref=%0d expected %0d %0d %0d %0d",
               id, loop_closed_o, contactor_o, duty_ol_o, i_ref_o, el, ec, ed, er);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1; check(1, 0, 0, 0, 0);   // R1 during reset
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    check(1, 0, 0, 0, 0);       // R1 after release
    for (int k = 0; k < NV; k++) begin
      i_req_i    = I_W'(VEC[k].ireq);
      u_sol_i    = V_W'(VEC[k].usol);
      u_bat_i    = V_W'(VEC[k].ubat);
      i_ind_i    = I_W'(VEC[k].iind);
      reg_duty_i = D_W'(VEC[k].rduty);
      reg_sat_i  = VEC[k].sat[0];
      repeat (VEC[k].n) @(posedge clk_i);
      #1 check(VEC[k].id, VEC[k].eloop, VEC[k].econt, VEC[k].eduty, VEC[k].eref);
    end
    // R12: start condition present but no tick
    u_sol_i = 16'd1051;
    tick_i  = 1'b0;
    repeat (5) @(posedge clk_i);
    #1 check(12, 0, 0, 0, 0);
    tick_i = 1'b1;
    @(posedge clk_i);
    #1 check(12, 1, 0, 0, 50);
    // R1: asynchronous reset mid-run
    rst_ni = 1'b0;
    #1 check(1, 0, 0, 0, 0);
    @(posedge clk_i);
    #1 rst_ni = 1'b1;
    check(1, 0, 0, 0, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule